// File: doc/BRIEF.md
# Power-State Sequencer for a Single-Clock Processor Subsystem

This block moves a small processor subsystem between three power states: full run, idle and stop. Software asks for a state change by writing a request bit into one of two control registers. The sequencer then gates the clocks it owns. These are the oscillator enable, the CPU clock enable, the watchdog clock enable and the peripheral clock enable. It also decides how the subsystem comes back to full run.

Idle keeps the oscillator and the peripheral clocks running and stops the CPU and watchdog clocks. Any pending peripheral or external interrupt ends idle. On the wake cycle the sequencer tells the CPU either to take the interrupt or to continue at the next instruction, depending on the interrupt master enable flag.

Stop shuts everything down, oscillator included. Only a dedicated release pin ends stop, and that pin can be sensed by level or by edge. After release the oscillator restarts at once, but the clocks stay gated for a programmable warm-up of 2^N input clocks. The CPU then continues at the next instruction. While the CPU clock runs, a machine-cycle strobe pulses once every four input clocks.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After a synchronous active-high reset the block is in full run. In that state all four enables are 1 and neither wake pulse is asserted. Reset also clears both request bits, selects level sensing and sets the warm-up exponent to all ones.
- R2: `mcycle_stb` is high for one cycle in every four consecutive cycles while the CPU clock enable stays high. It is never high while `cpu_clk_en` is 0.
- R3: Writing 1 to `ctl2_idle` with `ctl2_we` in full run sets the idle request. On the following clock the enables become osc=1, cpu=0, wdt=0, per=1. The request clears itself on entry, so after a wake the block stays in full run.
- R4: In idle, `periph_irq` or `ext_irq` at a clock edge returns the block to full run (all enables 1) at that edge. Idle persists while neither is high.
- R5: On the wake from idle, `wake_vector` pulses for one cycle if `imf` is 1. `wake_resume` pulses for one cycle if `imf` is 0.
- R6: Writing `ctl1_wdata` with bit 5 set and `ctl1_we` in full run requests stop. On the following clock all four enables become 0. Interrupt inputs are ignored in stop.
- R7: If stop and idle are requested in the same cycle, stop is entered. Both requests are cleared, so after release the block stays in full run.
- R8: With bit 4 of `ctl1_wdata` = 1 (edge sensing), stop ends on a rising edge of `stop_pin` after a two-flop synchronizer. The osc enable rises at the third clock edge after the pin rises, and a one-cycle pulse is enough. A pin already high at stop entry does not release.
- R9: With bit 4 = 0 (level sensing), stop ends when two consecutive synchronized samples of `stop_pin` are high. The osc enable rises at the fourth clock edge after the pin rises, and a one-cycle pulse does not release.
- R10: After release, osc=1 with the other enables 0 for exactly 2^N cycles, where N is `ctl1_wdata[3:0]`. The block then returns to full run with a one-cycle `wake_resume` pulse, whatever the value of `imf`.
- R11: Control register writes are accepted only in full run. Requests written in idle have no effect after the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (oscillator-rate) |
| rst | input | 1 | Synchronous active-high reset |
| ctl1_we | input | 1 | Write strobe for control register 1 |
| ctl1_wdata | input | WEXP_W+2 | [5] stop request, [4] edge sense, [3:0] warm-up exponent |
| ctl2_we | input | 1 | Write strobe for control register 2 |
| ctl2_idle | input | 1 | Idle request bit of control register 2 |
| periph_irq | input | 1 | Pending peripheral interrupt |
| ext_irq | input | 1 | Pending external interrupt |
| imf | input | 1 | Interrupt master enable flag |
| stop_pin | input | 1 | Asynchronous stop-release pin |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wake_vector | output | 1 | One-cycle pulse: service the interrupt first |
| wake_resume | output | 1 | One-cycle pulse: resume at the next instruction |
| mcycle_stb | output | 1 | Machine-cycle strobe, one per four clocks |

## Verification
The assertions assume that the clock keeps running in stop, so that the release synchronizer and the warm-up counter can advance. They also assume that `imf` and the interrupt inputs are stable around the wake edge. The bench drives every input half a period away from the rising edge. It lowers `stop_pin` and lets the synchronizer settle before each stop entry, except in the one case where a pin held high at entry is the point of the test. The warm-up sweep keeps N small so that each window can be counted exactly.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2,
    PM_WARM = 2'd3
  } pm_state_e;

  typedef struct packed {
    logic osc;
    logic cpu;
    logic wdt;
    logic per;
  } pm_gate_t;

  function automatic pm_gate_t gate_of(input pm_state_e s);
    pm_gate_t g;
    case (s)
      PM_RUN:  g = '{osc: 1'b1, cpu: 1'b1, wdt: 1'b1, per: 1'b1};
      PM_IDLE: g = '{osc: 1'b1, cpu: 1'b0, wdt: 1'b0, per: 1'b1};
      PM_WARM: g = '{osc: 1'b1, cpu: 1'b0, wdt: 1'b0, per: 1'b0};
      default: g = '{osc: 1'b0, cpu: 1'b0, wdt: 1'b0, per: 1'b0};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pm_release_qual.sv
module pm_release_qual #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  input  logic sense_edge,
  output logic release_o
);

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              rise;
  logic              held;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin_async};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise      = sync_q[SYNC_N-1] & ~prev_q;
  assign held      = sync_q[SYNC_N-1] & prev_q;
  assign release_o = sense_edge ? rise : held;

  // R8: a detected rising edge lasts exactly one cycle
  a_r8_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

  // R9: level release needs the previous synchronized sample high too
  a_r9_level_two_samples: assert property (@(posedge clk) disable iff (rst)
    held |-> $past(sync_q[SYNC_N-1]));

endmodule

// File: rtl/pm_warmup.sv
module pm_warmup #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [EXP_W-1:0] exp_n,
  output logic             done
);

  localparam int CNT_W = 1 << EXP_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim  = (CNT_W'(1) << exp_n) - CNT_W'(1);
  assign done = active && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R10: the count never runs past the programmed limit
  a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    active |-> cnt_q <= lim);

endmodule

// File: rtl/pm_mcycle.sv
module pm_mcycle #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic stb
);

  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      stb   <= 1'b0;
    end else begin
      if (en) begin
        div_q <= (div_q == DW'(DIV - 1)) ? '0 : div_q + DW'(1);
      end
      stb <= en && (div_q == DW'(DIV - 2));
    end
  end

  // R2: strobes are never back to back
  a_r2_stb_spaced: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int WEXP_W = 4,
  parameter int MC_DIV = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl1_we,
  input  logic [WEXP_W+1:0] ctl1_wdata,
  input  logic              ctl2_we,
  input  logic              ctl2_idle,
  input  logic              periph_irq,
  input  logic              ext_irq,
  input  logic              imf,
  input  logic              stop_pin,
  output logic              osc_en,
  output logic              cpu_clk_en,
  output logic              wdt_clk_en,
  output logic              per_clk_en,
  output logic              wake_vector,
  output logic              wake_resume,
  output logic              mcycle_stb
);

  localparam int STOP_BIT  = WEXP_W + 1;
  localparam int SENSE_BIT = WEXP_W;

  pm_state_e         state_q, state_nxt;
  pm_gate_t          gate_q, gate_nxt;
  logic              stop_q, idle_q, edge_q;
  logic [WEXP_W-1:0] wexp_q;
  logic              rel, wdone, irq_any;
  logic              wv_q, wr_q;

  assign irq_any = periph_irq | ext_irq;

  pm_release_qual #(.SYNC_N(SYNC_N)) rel_i (
    .clk        (clk),
    .rst        (rst),
    .pin_async  (stop_pin),
    .sense_edge (edge_q),
    .release_o  (rel)
  );

  pm_warmup #(.EXP_W(WEXP_W)) wup_i (
    .clk    (clk),
    .rst    (rst),
    .active (state_q == PM_WARM),
    .exp_n  (wexp_q),
    .done   (wdone)
  );

  // control register fields and self-clearing requests
  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      idle_q <= 1'b0;
      edge_q <= 1'b0;
      wexp_q <= '1;
    end else if (state_q == PM_RUN) begin
      if (ctl1_we) begin
        stop_q <= ctl1_wdata[STOP_BIT];
        edge_q <= ctl1_wdata[SENSE_BIT];
        wexp_q <= ctl1_wdata[WEXP_W-1:0];
      end
      if (ctl2_we) begin
        idle_q <= ctl2_idle;
      end
      if (stop_q) begin
        stop_q <= 1'b0;
        idle_q <= 1'b0;
      end else if (idle_q) begin
        idle_q <= 1'b0;
      end
    end
  end

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      PM_RUN: begin
        if (stop_q)      state_nxt = PM_STOP;
        else if (idle_q) state_nxt = PM_IDLE;
      end
      PM_IDLE: if (irq_any) state_nxt = PM_RUN;
      PM_STOP: if (rel)     state_nxt = PM_WARM;
      PM_WARM: if (wdone)   state_nxt = PM_RUN;
      default:              state_nxt = PM_RUN;
    endcase
  end

  assign gate_nxt = gate_of(state_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PM_RUN;
      gate_q  <= gate_of(PM_RUN);
      wv_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_nxt;
      gate_q  <= gate_nxt;
      wv_q    <= (state_q == PM_IDLE) && irq_any && imf;
      wr_q    <= ((state_q == PM_IDLE) && irq_any && !imf) ||
                 ((state_q == PM_WARM) && wdone);
    end
  end

  pm_mcycle #(.DIV(MC_DIV)) mc_i (
    .clk (clk),
    .rst (rst),
    .en  (gate_nxt.cpu),
    .stb (mcycle_stb)
  );

  assign osc_en      = gate_q.osc;
  assign cpu_clk_en  = gate_q.cpu;
  assign wdt_clk_en  = gate_q.wdt;
  assign per_clk_en  = gate_q.per;
  assign wake_vector = wv_q;
  assign wake_resume = wr_q;

  a_r1_reset_run: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (osc_en && cpu_clk_en && wdt_clk_en && per_clk_en &&
                    !wake_vector && !wake_resume));

  a_r2_stb_gated: assert property (@(posedge clk) disable iff (rst)
    mcycle_stb |-> cpu_clk_en);

  a_r3_idle_gates: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_IDLE) |-> (osc_en && !cpu_clk_en && !wdt_clk_en && per_clk_en));

  a_r5_wake_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wake_vector && wake_resume));

  a_r6_stop_gates: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_STOP) |-> !(osc_en || cpu_clk_en || wdt_clk_en || per_clk_en));

  a_r7_stop_first: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state_q == PM_RUN) && $past(stop_q)) |-> (state_q == PM_STOP));

  a_r10_warm_gates: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_WARM) |-> (osc_en && !cpu_clk_en && !wdt_clk_en && !per_clk_en));

endmodule

// File: tb/pwrmode_ctrl_tb_top.sv
module pwrmode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl1_we = 0, ctl2_we = 0, ctl2_idle = 0;
  logic [5:0] ctl1_wdata = '0;
  logic       periph_irq = 0, ext_irq = 0, imf = 0, stop_pin = 0;
  logic       osc_en, cpu_clk_en, wdt_clk_en, per_clk_en;
  logic       wake_vector, wake_resume, mcycle_stb;

  int n_chk = 0, n_err = 0, stb_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrmode_ctrl dut_i (
    .clk(clk), .rst(rst), .ctl1_we(ctl1_we), .ctl1_wdata(ctl1_wdata),
    .ctl2_we(ctl2_we), .ctl2_idle(ctl2_idle), .periph_irq(periph_irq),
    .ext_irq(ext_irq), .imf(imf), .stop_pin(stop_pin), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .wdt_clk_en(wdt_clk_en), .per_clk_en(per_clk_en),
    .wake_vector(wake_vector), .wake_resume(wake_resume), .mcycle_stb(mcycle_stb)
  );

  // gate code: {osc,cpu,wdt,per}; run=15 idle=9 warm=8 stop=0
  function automatic int gates();
    return int'({osc_en, cpu_clk_en, wdt_clk_en, per_clk_en});
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr1(input bit stp, input bit edg, input int n);
    ctl1_we = 1; ctl1_wdata = {stp, edg, 4'(n)};
    step(1);
    ctl1_we = 0;
  endtask

  task automatic wr2_idle();
    ctl2_we = 1; ctl2_idle = 1;
    step(1);
    ctl2_we = 0; ctl2_idle = 0;
  endtask

  always @(negedge clk) if (!rst && mcycle_stb && !cpu_clk_en) stb_bad++;

  task automatic idle_case(input bit imf_v, input bit src);
    wr2_idle();
    check_eq("R3 run until entry", gates(), 15);
    step(1);
    check_eq("R3 idle gates", gates(), 9);
    step(3);
    check_eq("R4 idle held", gates(), 9);
    imf = imf_v;
    if (src) periph_irq = 1; else ext_irq = 1;
    step(1);
    periph_irq = 0; ext_irq = 0;
    check_eq("R4 wake gates", gates(), 15);
    check_eq("R5 wake_vector", int'(wake_vector), int'(imf_v));
    check_eq("R5 wake_resume", int'(wake_resume), int'(!imf_v));
    step(1);
    check_eq("R5 pulse width", int'(wake_vector | wake_resume), 0);
    step(5);
    check_eq("R3 self clear", gates(), 15);
  endtask

  task automatic stop_case(input bit edg, input int n);
    int lat;
    lat = edg ? 3 : 4;
    wr1(1, edg, n);
    check_eq("R6 run until entry", gates(), 15);
    step(1);
    check_eq("R6 stop gates", gates(), 0);
    periph_irq = 1; ext_irq = 1; imf = 1;
    step(4);
    periph_irq = 0; ext_irq = 0;
    check_eq("R6 irq ignored", gates(), 0);
    stop_pin = 1;
    step(lat - 1);
    check_eq(edg ? "R8 before release" : "R9 before release", gates(), 0);
    step(1);
    check_eq(edg ? "R8 release" : "R9 release", gates(), 8);
    if ((1 << n) - 1 > 0) begin
      step((1 << n) - 1);
      check_eq("R10 warm last cycle", gates(), 8);
    end
    step(1);
    check_eq("R10 back to run", gates(), 15);
    check_eq("R10 resume pulse", int'(wake_resume), 1);
    check_eq("R10 no vector", int'(wake_vector), 0);
    step(1);
    check_eq("R10 pulse width", int'(wake_resume), 0);
    stop_pin = 0; imf = 0;
    step(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int last, cnt;
    step(3);
    rst = 0;
    step(1);
    check_eq("R1 reset gates", gates(), 15);
    check_eq("R1 no wake", int'(wake_vector | wake_resume), 0);

    last = -1; cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (mcycle_stb) begin
        if (last >= 0) check_eq("R2 strobe spacing", i - last, 4);
        last = i; cnt++;
      end
      step(1);
    end
    check_eq("R2 strobe count", cnt, 10);

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        idle_case(m[0], s[0]);

    for (int e = 0; e < 2; e++)
      for (int n = 0; n < 6; n++)
        stop_case(e[0], n);

    // R9: single-cycle pulse in level mode does not release
    wr1(1, 0, 2); step(1);
    stop_pin = 1; step(1); stop_pin = 0;
    step(8);
    check_eq("R9 short pulse ignored", gates(), 0);
    stop_pin = 1; step(4);
    check_eq("R9 held release", gates(), 8);
    step(4);
    check_eq("R10 n=2 run", gates(), 15);
    stop_pin = 0; step(3);

    // R8: single-cycle pulse in edge mode releases
    wr1(1, 1, 1); step(1);
    stop_pin = 1; step(1); stop_pin = 0;
    step(2);
    check_eq("R8 short pulse release", gates(), 8);
    step(2);
    check_eq("R10 n=1 run", gates(), 15);
    step(3);

    // R8: pin high at entry does not release in edge mode
    stop_pin = 1; step(4);
    wr1(1, 1, 1); step(1);
    step(8);
    check_eq("R8 high at entry", gates(), 0);
    stop_pin = 0; step(3);
    stop_pin = 1; step(3);
    check_eq("R8 later edge", gates(), 8);
    step(2);
    check_eq("R10 run after edge", gates(), 15);
    stop_pin = 0; step(3);

    // R7: simultaneous requests
    ctl1_we = 1; ctl1_wdata = {1'b1, 1'b0, 4'd1};
    ctl2_we = 1; ctl2_idle = 1;
    step(1);
    ctl1_we = 0; ctl2_we = 0; ctl2_idle = 0;
    step(1);
    check_eq("R7 stop wins", gates(), 0);
    stop_pin = 1; step(4);
    check_eq("R7 release", gates(), 8);
    step(2);
    stop_pin = 0;
    step(6);
    check_eq("R7 idle cleared", gates(), 15);

    // R11: writes in idle are ignored
    wr2_idle(); step(1);
    check_eq("R11 in idle", gates(), 9);
    ctl1_we = 1; ctl1_wdata = {1'b1, 1'b1, 4'd0};
    ctl2_we = 1; ctl2_idle = 1;
    step(1);
    ctl1_we = 0; ctl2_we = 0; ctl2_idle = 0;
    ext_irq = 1; step(1); ext_irq = 0;
    check_eq("R11 woke", gates(), 15);
    step(6);
    check_eq("R11 no late request", gates(), 15);

    check_eq("R2 no strobe while gated", stb_bad, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule